// File: doc/BRIEF.md
# Commit Trace Packer with Start/Stop Trigger

This block sits next to a processor's retirement stage and turns its per-cycle commit stream into wide trace words for a host-bound stream. In every clock it may see up to seven retired instructions, given oldest first. Each one carries an address, its instruction encoding and a valid flag. The block also keeps a free-running cycle counter. It builds one 512-bit word for each cycle that has at least one commit and is selected for recording. The word holds the cycle number and the packed commit entries. Words leave through a valid/ready output, behind a small FIFO that absorbs back-pressure and reports lost words through a sticky flag.

Recording is controlled by a two-state trigger machine. In state `TS_ARMED` a cycle is recorded only if the trigger is disabled, or if one of its valid commits carries the programmed start encoding. The second case takes the transition *arm-to-record* into `TS_RECORD`. In `TS_RECORD` every commit cycle is recorded, and a valid commit carrying the stop encoding takes the transition *record-to-arm* back to `TS_ARMED`. The *force-arm* transition to `TS_ARMED` happens whenever the trigger is disabled, and also on any write to the control register. Software loads the start value, the stop value and the enable bit through a small register write port.

Top module: `ctrace_packer`

## Requirements
- R1: Bits 63:0 of each word hold the cycle counter value of the clock in which the commits were presented. The counter is 0 in the first clock after reset is released and advances by one every clock, whatever the trigger state.
- R2: Commit slot k (k = 0..6) occupies bits 64*(k+1)+63 : 64*(k+1). A valid entry holds the 40-bit address in bits 39:0 and a 1 in bit 40. Bits 63:41 are zero. Slot 0 is the oldest commit of the cycle.
- R3: A slot whose valid flag is clear is written as all zeros. Valid flags are taken as contiguous from slot 0 upward.
- R4: A clock with no valid commit produces no word.
- R5: With the enable bit (control register bit 0) clear, every clock with at least one commit produces a word.
- R6: With the trigger enabled and in `TS_ARMED`, a commit clock is dropped unless a valid commit's encoding equals the start value. A clock that does match is recorded and moves the machine to `TS_RECORD`. A stop value seen in `TS_ARMED` is ignored.
- R7: In `TS_RECORD` every commit clock is recorded. A start value there is ignored. A clock whose valid commits include the stop value is recorded, and later clocks are dropped until the next start. A clock with both start and stop in `TS_ARMED` starts recording and does not stop it.
- R8: A word is presented on `out_data` with `out_valid` high after the first clock edge that follows its commit clock. Words leave in commit order. While `out_valid` is high and `out_ready` is low, the word is held unchanged.
- R9: Up to FIFO_DEPTH (default 4) words wait for `out_ready`. A word arriving when the FIFO is full and no word leaves in that clock is dropped. Such a drop sets `overflow`, which stays set until reset.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_addr`: address 0 holds the start value, address 1 the stop value, and address 2 the enable bit in bit 0. The new value takes effect from the next clock. Any write to address 2 returns the machine to `TS_ARMED`.
- R11: After reset `out_valid` and `overflow` are low, the trigger is disabled, and the start and stop values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 start, 1 stop, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cm_valid | input | 7 | Per-slot commit valid, contiguous from slot 0 |
| cm_addr | input | 280 | Per-slot 40-bit commit address, slot k at bits 40k+39:40k |
| cm_insn | input | 224 | Per-slot 32-bit instruction encoding, slot k at bits 32k+31:32k |
| out_ready | input | 1 | Downstream accepts the presented word |
| out_valid | output | 1 | A trace word is presented |
| out_data | output | 512 | Trace word |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
A trigger machine stuck in the wrong state shows at the ports in the very next commit clock. One edge later a word appears that should have been dropped, or an expected word is missing. A slip in the cycle counter or in the slot packing shows in the first word that reaches `out_data`. FIFO pointer or count errors show as a reordered, repeated or missing word, or as an `overflow` change one edge after the FIFO first fills. The bench models every clock and compares `out_valid`, the head word and `overflow` in every cycle, so a fault is caught within one or two clocks of its cause.

// File: rtl/ctrace_pkg.sv
package ctrace_pkg;
    localparam int CYC_W   = 64;
    localparam int ENTRY_W = 64;
    localparam int WORD_W  = 512;
    localparam int MAX_SLOTS = (WORD_W - CYC_W) / ENTRY_W;

    localparam logic [1:0] CFG_START = 2'd0;
    localparam logic [1:0] CFG_STOP  = 2'd1;
    localparam logic [1:0] CFG_CTRL  = 2'd2;

    typedef enum logic {
        TS_ARMED  = 1'b0,
        TS_RECORD = 1'b1
    } trig_state_t;
endpackage

// File: rtl/ctrace_trigger.sv
module ctrace_trigger
    import ctrace_pkg::*;
#(
    parameter int SLOTS  = 7,
    parameter int INSN_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_addr,
    input  logic [INSN_W-1:0]       cfg_wdata,
    input  logic [SLOTS-1:0]        cm_valid,
    input  logic [SLOTS*INSN_W-1:0] cm_insn,
    output logic                    capture
);
    logic [INSN_W-1:0] start_q, stop_q;
    logic              en_q;
    logic [SLOTS-1:0]  hit_start_v, hit_stop_v;
    logic              hit_start, hit_stop, any_commit, ctrl_wr;
    trig_state_t       st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            stop_q  <= '0;
            en_q    <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_START) start_q <= cfg_wdata;
            if (cfg_addr == CFG_STOP)  stop_q  <= cfg_wdata;
            if (cfg_addr == CFG_CTRL)  en_q    <= cfg_wdata[0];
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_match
        assign hit_start_v[k] = cm_valid[k] && (cm_insn[k*INSN_W +: INSN_W] == start_q);
        assign hit_stop_v[k]  = cm_valid[k] && (cm_insn[k*INSN_W +: INSN_W] == stop_q);
    end

    assign hit_start  = |hit_start_v;
    assign hit_stop   = |hit_stop_v;
    assign any_commit = |cm_valid;
    assign ctrl_wr    = cfg_we && (cfg_addr == CFG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TS_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        unique case (st_q)
            TS_ARMED: begin
                capture = any_commit && (!en_q || hit_start);
                if (en_q && hit_start) st_d = TS_RECORD;
            end
            TS_RECORD: begin
                capture = any_commit;
                if (hit_stop) st_d = TS_ARMED;
            end
            default: st_d = TS_ARMED;
        endcase
        if (!en_q || ctrl_wr) st_d = TS_ARMED;
    end
endmodule

// File: rtl/ctrace_pack.sv
module ctrace_pack
    import ctrace_pkg::*;
#(
    parameter int SLOTS  = 7,
    parameter int ADDR_W = 40
) (
    input  logic [SLOTS-1:0]        cm_valid,
    input  logic [SLOTS*ADDR_W-1:0] cm_addr,
    input  logic [CYC_W-1:0]        cycle,
    output logic [WORD_W-1:0]       word
);
    localparam int PAD_W  = ENTRY_W - ADDR_W - 1;
    localparam int USED_W = CYC_W + SLOTS * ENTRY_W;

    assign word[CYC_W-1:0] = cycle;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign word[CYC_W + k*ENTRY_W +: ENTRY_W] =
            cm_valid[k] ? {{PAD_W{1'b0}}, 1'b1, cm_addr[k*ADDR_W +: ADDR_W]} : '0;
    end

    if (USED_W < WORD_W) begin : g_tail
        assign word[WORD_W-1:USED_W] = '0;
    end
endmodule

// File: rtl/ctrace_fifo.sv
module ctrace_fifo #(
    parameter int W     = 512,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_pop, do_push, ovf_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push && !do_push) ovf_q <= 1'b1;
        end
    end

    assign dout      = mem[rd_q];
    assign not_empty = (cnt_q != '0);
    assign overflow  = ovf_q;
endmodule

// File: rtl/ctrace_packer.sv
module ctrace_packer
    import ctrace_pkg::*;
#(
    parameter int SLOTS      = 7,
    parameter int ADDR_W     = 40,
    parameter int INSN_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_addr,
    input  logic [INSN_W-1:0]       cfg_wdata,
    input  logic [SLOTS-1:0]        cm_valid,
    input  logic [SLOTS*ADDR_W-1:0] cm_addr,
    input  logic [SLOTS*INSN_W-1:0] cm_insn,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_data,
    output logic                    overflow
);
    logic [CYC_W-1:0]  cyc_q;
    logic [WORD_W-1:0] word;
    logic              capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
    end

    ctrace_trigger #(.SLOTS(SLOTS), .INSN_W(INSN_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cm_valid  (cm_valid),
        .cm_insn   (cm_insn),
        .capture   (capture)
    );

    ctrace_pack #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_pack (
        .cm_valid (cm_valid),
        .cm_addr  (cm_addr),
        .cycle    (cyc_q),
        .word     (word)
    );

    ctrace_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (capture),
        .din       (word),
        .pop       (out_ready),
        .dout      (out_data),
        .not_empty (out_valid),
        .overflow  (overflow)
    );
endmodule

// File: rtl/ctrace_packer_chk.sv
module ctrace_packer_chk
    import ctrace_pkg::*;
#(
    parameter int SLOTS  = 7,
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              overflow
);
    logic [CYC_W-1:0] last_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            last_q <= out_data[CYC_W-1:0];
            seen_q <= 1'b1;
        end
    end

    p_reset_state_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overflow));

    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_nonempty_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[CYC_W + ADDR_W]);

    p_cycle_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && seen_q) |-> (out_data[CYC_W-1:0] > last_q));

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
        localparam int B = CYC_W + k * ENTRY_W;
        p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[B + ENTRY_W - 1 : B + ADDR_W + 1] == '0));
        if (k > 0) begin : g_contig
            p_contig_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_data[B + ADDR_W]) |-> out_data[B - ENTRY_W + ADDR_W]);
        end
    end
endmodule

bind ctrace_packer ctrace_packer_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .overflow  (overflow)
);

// File: tb/sim_ctrace_packer.sv
module sim_ctrace_packer;
    localparam int CLK_P  = 10;
    localparam int SLOTS  = 7;
    localparam int ADDR_W = 40;
    localparam int INSN_W = 32;
    localparam int DEPTH  = 4;
    localparam int WORD_W = 512;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [1:0]              cfg_addr = '0;
    logic [INSN_W-1:0]       cfg_wdata = '0;
    logic [SLOTS-1:0]        cm_valid = '0;
    logic [SLOTS*ADDR_W-1:0] cm_addr = '0;
    logic [SLOTS*INSN_W-1:0] cm_insn = '0;
    logic                    out_ready = 1'b0;
    logic                    out_valid;
    logic [WORD_W-1:0]       out_data;
    logic                    overflow;

    ctrace_packer #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .INSN_W(INSN_W), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_insn(cm_insn), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [WORD_W-1:0] q[$];
    bit                m_en = 1'b0, m_rec = 1'b0, m_ovf = 1'b0;
    logic [31:0]       m_start = '0, m_stop = '0;
    longint unsigned   ecyc = 0;
    int                n_cmp = 0, n_bad = 0;
    string             phase = "R11";
    bit                done = 1'b0;

    always @(posedge clk) if (rst_n) ecyc <= ecyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mk_word(input longint unsigned cyc, input int n,
                                                  input logic [SLOTS*ADDR_W-1:0] a);
        logic [WORD_W-1:0] w = '0;
        w[63:0] = cyc;
        for (int k = 0; k < n; k++) begin
            w[64 + 64*k +: 40] = a[40*k +: 40];
            w[64 + 64*k + 40]  = 1'b1;
        end
        return w;
    endfunction

    task automatic step(input int n, input bit rdy,
                        input bit wr = 1'b0, input logic [1:0] wa = 2'd0, input logic [31:0] wd = '0,
                        input int sa = -1, input logic [31:0] va = '0,
                        input int sb = -1, input logic [31:0] vb = '0);
        logic [SLOTS*ADDR_W-1:0] a;
        logic [SLOTS*INSN_W-1:0] ins;
        bit ms, mp, cap;
        @(negedge clk);
        chk(out_valid === (q.size() != 0), "R8", "out_valid", WORD_W'(out_valid), WORD_W'(q.size() != 0));
        if (q.size() != 0) chk(out_data === q[0], {phase, " R2 word"}, "out_data", out_data, q[0]);
        chk(overflow === m_ovf, "R9", "overflow", WORD_W'(overflow), WORD_W'(m_ovf));
        for (int k = 0; k < SLOTS; k++) begin
            a[k*ADDR_W +: ADDR_W]   = ADDR_W'({$urandom(), $urandom()});
            ins[k*INSN_W +: INSN_W] = $urandom();
        end
        if (sa >= 0) ins[sa*INSN_W +: INSN_W] = va;
        if (sb >= 0) ins[sb*INSN_W +: INSN_W] = vb;
        cm_valid  = SLOTS'((1 << n) - 1);
        cm_addr   = a;
        cm_insn   = ins;
        out_ready = rdy;
        cfg_we    = wr;
        cfg_addr  = wa;
        cfg_wdata = wd;
        ms = 1'b0;
        mp = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (ins[k*INSN_W +: INSN_W] == m_start) ms = 1'b1;
            if (ins[k*INSN_W +: INSN_W] == m_stop)  mp = 1'b1;
        end
        cap = (n > 0) && (!m_en || m_rec || ms);
        if (m_en) begin
            if (!m_rec && ms)     m_rec = 1'b1;
            else if (m_rec && mp) m_rec = 1'b0;
        end else m_rec = 1'b0;
        if (q.size() != 0 && rdy) void'(q.pop_front());
        if (cap) begin
            if (q.size() >= DEPTH) m_ovf = 1'b1;
            else q.push_back(mk_word(ecyc, n, a));
        end
        if (wr) begin
            case (wa)
                2'd0: m_start = wd;
                2'd1: m_stop  = wd;
                2'd2: begin m_en = wd[0]; m_rec = 1'b0; end
                default: ;
            endcase
        end
    endtask

    localparam logic [31:0] ST_V = 32'h0000_600b;
    localparam logic [31:0] SP_V = 32'h0000_700b;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R11", "out_valid in reset", WORD_W'(out_valid), '0);
        chk(overflow === 1'b0, "R11", "overflow in reset", WORD_W'(overflow), '0);
        rst_n = 1'b1;

        phase = "R4";
        repeat (3) step(0, 1);
        step(3, 1);
        repeat (2) step(0, 1);

        phase = "R5 R1";
        repeat (3) step(7, 1);
        step(1, 1);
        step(5, 1);

        phase = "R10";
        step(0, 1, 1'b1, 2'd0, ST_V);
        step(0, 1, 1'b1, 2'd1, SP_V);
        step(0, 1, 1'b1, 2'd2, 32'd1);

        phase = "R6";
        repeat (3) step(4, 1);
        step(2, 1, 1'b0, 2'd0, '0, 1, SP_V);
        step(3, 1, 1'b0, 2'd0, '0, 2, ST_V);
        step(2, 1);
        step(1, 1, 1'b0, 2'd0, '0, 0, ST_V);

        phase = "R7";
        step(2, 1, 1'b0, 2'd0, '0, 1, SP_V);
        step(3, 1);
        step(2, 1, 1'b0, 2'd0, '0, 0, SP_V);
        step(3, 1, 1'b0, 2'd0, '0, 0, ST_V, 1, SP_V);
        step(2, 1);
        step(1, 1, 1'b0, 2'd0, '0, 0, SP_V);
        step(2, 1);

        phase = "R10 rearm";
        step(2, 1, 1'b0, 2'd0, '0, 0, ST_V);
        step(0, 1, 1'b1, 2'd2, 32'd1);
        step(2, 1);
        step(0, 1);

        phase = "R8 R9";
        step(0, 1, 1'b1, 2'd2, 32'd0);
        repeat (7) step(2, 0);
        repeat (3) step(0, 0);
        repeat (6) step(0, 1);
        chk(overflow === 1'b1, "R9", "sticky overflow", WORD_W'(overflow), WORD_W'(1));

        phase = "R1 R3 random";
        for (int i = 0; i < 3000; i++) begin
            int n;
            int r;
            n = int'($urandom_range(0, 9));
            if (n > SLOTS) n = (n == 8) ? 0 : SLOTS;
            r = int'($urandom_range(0, 39));
            if (r == 0)      step(n, ($urandom_range(0, 3) != 0), 1'b1, 2'd2, {31'd0, 1'b1});
            else if (r == 1) step(n, ($urandom_range(0, 3) != 0), 1'b1, 2'd2, 32'd0);
            else if (r < 6 && n > 0)
                step(n, ($urandom_range(0, 3) != 0), 1'b0, 2'd0, '0, int'($urandom_range(0, n-1)), ST_V);
            else if (r < 10 && n > 0)
                step(n, ($urandom_range(0, 3) != 0), 1'b0, 2'd0, '0, int'($urandom_range(0, n-1)), SP_V);
            else
                step(n, ($urandom_range(0, 3) != 0));
        end
        repeat (8) step(0, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule